// File: doc/BRIEF.md
# DDR2 Refresh Scheduler with Backlog

This block decides when a DDR2 device is owed a refresh and places the refresh commands on the shared command bus. A free-running interval counter, whose period is set by a rate input, adds one owed refresh to a saturating backlog each time it expires. No input can stop this. While refreshes are owed, the block requests the command bus from the system arbiter. It marks the request urgent once the backlog reaches a threshold. The arbiter is expected to serve a non-urgent request only when the bus is idle, and an urgent one at the next command boundary.

Once granted, the block issues a precharge-all and then an autorefresh. It pulses a page-invalidate output alongside the precharge, so that the arbiter's open-page state is discarded and the next access counts as a page miss. It then holds the bus for a programmable number of NOP cycles before letting go. The bus handshake is a level request and grant. Once the arbiter has seen the request, it may stall the block for any number of cycles by holding the grant low. Once the grant has been seen high in the waiting cycle, the bus belongs to the block until the block drops its request.

A self-refresh request takes the same bus path. It issues a precharge-all, then a self-refresh entry with the clock-enable dropped, and holds clock-enable low while the request stays high. When the request is released, clock-enable rises and a programmable number of NOP cycles passes. The backlog is then cleared and the bus is released.

Top module: `refresh_sched`

## Requirements
- R1: After reset, req_o, urgent_o and page_inv_o are 0, cmd_o is NOP (2'd0), cke_o is 1 and pending_o is 0.
- R2: The interval counter expires once every rate_i+1 cycles, and each expiry adds one to pending_o. After N clock edges since reset, with no refresh issued, pending_o equals N/(rate_i+1), rounded down.
- R3: pending_o saturates at 2**BL_W-1 (15 by default) and never wraps to a lower value on a further expiry.
- R4: req_o rises in the cycle after pending_o first becomes non-zero and stays high while the grant is withheld. While waiting, urgent_o is 1 exactly when pending_o >= thresh_i.
- R5: In the cycle after gnt_i is seen high while waiting, cmd_o is precharge-all (2'd1) with page_inv_o high for that one cycle. The next cycle is autorefresh (2'd2), and pending_o drops by one at the following edge (an expiry at that same edge cancels the drop).
- R6: After the autorefresh, exactly trfc_i (at least 1) cycles of NOP follow with req_o high, and then req_o falls. cmd_o is NOP whenever req_o is low.
- R7: Interval expiries keep adding to pending_o during a refresh sequence and during self-refresh. The count of owed refreshes is always expiries minus autorefresh commands issued.
- R8: With sr_req_i high in an idle cycle, the granted sequence is precharge-all, then self-refresh entry (2'd3) with cke_o low. cke_o then stays low, with NOP and req_o high, until sr_req_i falls.
- R9: After sr_req_i falls, cke_o is high for exactly xsr_i (at least 1) NOP cycles with req_o high. Then req_o falls and pending_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_i | input | RATE_W | Refresh interval; the period is rate_i+1 cycles |
| trfc_i | input | GAP_W | NOP cycles held after each autorefresh |
| xsr_i | input | GAP_W | NOP cycles held after self-refresh exit |
| thresh_i | input | BL_W | Backlog level at which the request becomes urgent |
| sr_req_i | input | 1 | Level request to enter and stay in self-refresh |
| gnt_i | input | 1 | Bus grant from the command arbiter |
| req_o | output | 1 | Bus request; high for the whole owned sequence |
| urgent_o | output | 1 | High-priority marker on a waiting refresh request |
| cmd_o | output | 2 | Command: 0 NOP, 1 precharge-all, 2 autorefresh, 3 self-refresh entry |
| cke_o | output | 1 | Clock enable to the device |
| page_inv_o | output | 1 | One-cycle pulse invalidating all open-page state |
| pending_o | output | BL_W | Refreshes owed but not yet issued |

## Verification
On every cycle the assertions check the following local rules. Autorefresh only ever follows a precharge-all. The invalidate pulse coincides with the precharge. Any non-NOP command is issued under a held request. Urgency is never shown without a request. The backlog neither wraps at its ceiling nor grows across an autorefresh, and clock-enable is low only under an owned bus. Other properties depend on the actual period of the interval counter, the exact length of the post-refresh and self-refresh-exit gaps, and the backlog arithmetic of expiries minus refreshes. The bench's scenarios cover these by sweeping rates, gaps and thresholds against closed-form counts.

// File: rtl/refresh_sched_pkg.sv
package refresh_sched_pkg;
  typedef enum logic [1:0] {
    CMD_NOP  = 2'd0,
    CMD_PREA = 2'd1,
    CMD_AREF = 2'd2,
    CMD_SREF = 2'd3
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT, ST_PREA, ST_AREF, ST_GAP, ST_SRE, ST_SR, ST_SRX
  } state_e;
endpackage

// File: rtl/refresh_interval.sv
module refresh_interval #(
  parameter int RATE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RATE_W-1:0] rate_i,
  output logic              tick_o
);
  logic [RATE_W-1:0] cnt_q;

  // expire when the count reaches the rate; a lowered rate expires at once
  assign tick_o = (cnt_q >= rate_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/refresh_backlog.sv
module refresh_backlog #(
  parameter int BL_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            inc_i,
  input  logic            dec_i,
  input  logic            clr_i,
  output logic [BL_W-1:0] count_o
);
  localparam logic [BL_W-1:0] CEIL = {BL_W{1'b1}};

  logic [BL_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)                                  cnt_d = '0;
    else if (inc_i && !dec_i && cnt_q != CEIL)  cnt_d = cnt_q + 1'b1;
    else if (dec_i && !inc_i && cnt_q != '0)    cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/refresh_fsm.sv
module refresh_fsm
  import refresh_sched_pkg::*;
#(
  parameter int BL_W  = 4,
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BL_W-1:0]  pending_i,
  input  logic [BL_W-1:0]  thresh_i,
  input  logic [GAP_W-1:0] trfc_i,
  input  logic [GAP_W-1:0] xsr_i,
  input  logic             sr_req_i,
  input  logic             gnt_i,
  output logic             req_o,
  output logic             urgent_o,
  output logic [1:0]       cmd_o,
  output logic             cke_o,
  output logic             page_inv_o,
  output logic             issue_o,
  output logic             clr_o
);
  state_e           st_q, st_d;
  logic             sr_q, sr_d;
  logic [GAP_W-1:0] gap_q, gap_d;
  logic             gap_last;

  assign gap_last = (gap_q <= GAP_W'(1));

  always_comb begin
    st_d  = st_q;
    sr_d  = sr_q;
    gap_d = gap_q;
    clr_o = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (sr_req_i) begin
          st_d = ST_WAIT;
          sr_d = 1'b1;
        end else if (pending_i != '0) begin
          st_d = ST_WAIT;
          sr_d = 1'b0;
        end
      end
      ST_WAIT: if (gnt_i) st_d = ST_PREA;
      ST_PREA: st_d = sr_q ? ST_SRE : ST_AREF;
      ST_AREF: begin
        st_d  = ST_GAP;
        gap_d = trfc_i;
      end
      ST_GAP: begin
        if (gap_last) st_d = ST_IDLE;
        else          gap_d = gap_q - 1'b1;
      end
      ST_SRE: st_d = ST_SR;
      ST_SR: begin
        if (!sr_req_i) begin
          st_d  = ST_SRX;
          gap_d = xsr_i;
        end
      end
      ST_SRX: begin
        if (gap_last) begin
          st_d  = ST_IDLE;
          clr_o = 1'b1;
        end else begin
          gap_d = gap_q - 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      sr_q  <= 1'b0;
      gap_q <= '0;
    end else begin
      st_q  <= st_d;
      sr_q  <= sr_d;
      gap_q <= gap_d;
    end
  end

  always_comb begin
    cmd_o = CMD_NOP;
    case (st_q)
      ST_PREA: cmd_o = CMD_PREA;
      ST_AREF: cmd_o = CMD_AREF;
      ST_SRE:  cmd_o = CMD_SREF;
      default: cmd_o = CMD_NOP;
    endcase
  end

  assign req_o      = (st_q != ST_IDLE);
  assign urgent_o   = (st_q == ST_WAIT) && !sr_q && (pending_i >= thresh_i);
  assign cke_o      = !((st_q == ST_SRE) || (st_q == ST_SR));
  assign page_inv_o = (st_q == ST_PREA);
  assign issue_o    = (st_q == ST_AREF);
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched #(
  parameter int RATE_W = 16,
  parameter int BL_W   = 4,
  parameter int GAP_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RATE_W-1:0] rate_i,
  input  logic [GAP_W-1:0]  trfc_i,
  input  logic [GAP_W-1:0]  xsr_i,
  input  logic [BL_W-1:0]   thresh_i,
  input  logic              sr_req_i,
  input  logic              gnt_i,
  output logic              req_o,
  output logic              urgent_o,
  output logic [1:0]        cmd_o,
  output logic              cke_o,
  output logic              page_inv_o,
  output logic [BL_W-1:0]   pending_o
);
  logic tick;
  logic issue;
  logic backlog_clr;

  refresh_interval #(.RATE_W(RATE_W)) u_interval (
    .clk    (clk),
    .rst_n  (rst_n),
    .rate_i (rate_i),
    .tick_o (tick)
  );

  refresh_backlog #(.BL_W(BL_W)) u_backlog (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc_i   (tick),
    .dec_i   (issue),
    .clr_i   (backlog_clr),
    .count_o (pending_o)
  );

  refresh_fsm #(.BL_W(BL_W), .GAP_W(GAP_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .pending_i  (pending_o),
    .thresh_i   (thresh_i),
    .trfc_i     (trfc_i),
    .xsr_i      (xsr_i),
    .sr_req_i   (sr_req_i),
    .gnt_i      (gnt_i),
    .req_o      (req_o),
    .urgent_o   (urgent_o),
    .cmd_o      (cmd_o),
    .cke_o      (cke_o),
    .page_inv_o (page_inv_o),
    .issue_o    (issue),
    .clr_o      (backlog_clr)
  );
endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk #(
  parameter int BL_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_o,
  input logic            urgent_o,
  input logic [1:0]      cmd_o,
  input logic            cke_o,
  input logic            page_inv_o,
  input logic [BL_W-1:0] pending_o,
  input logic            backlog_clr
);
  localparam logic [BL_W-1:0] CEIL = {BL_W{1'b1}};

  // R5
  aref_after_prea_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == 2'd2) |-> ($past(cmd_o) == 2'd1));

  // R5
  inv_with_prea_chk: assert property (@(posedge clk) disable iff (!rst_n)
    page_inv_o |-> (cmd_o == 2'd1));

  // R5
  aref_no_growth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == 2'd2) |=> (pending_o <= $past(pending_o)));

  // R6
  cmd_owns_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o != 2'd0) |-> req_o);

  // R4
  urgent_has_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    urgent_o |-> (req_o && pending_o != '0));

  // R3
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_o == CEIL && cmd_o != 2'd2 && !backlog_clr) |=> (pending_o == CEIL));

  // R8
  sref_cke_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == 2'd3) |-> !cke_o);

  // R8
  cke_low_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cke_o |-> req_o);

  // R9
  exit_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    backlog_clr |=> (pending_o == '0));
endmodule

bind refresh_sched refresh_sched_chk #(.BL_W(BL_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_o       (req_o),
  .urgent_o    (urgent_o),
  .cmd_o       (cmd_o),
  .cke_o       (cke_o),
  .page_inv_o  (page_inv_o),
  .pending_o   (pending_o),
  .backlog_clr (backlog_clr)
);

// File: tb/test_refresh_sched.sv
module test_refresh_sched;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] rate_i = 16'd9;
  logic [7:0]  trfc_i = 8'd2;
  logic [7:0]  xsr_i = 8'd2;
  logic [3:0]  thresh_i = 4'd3;
  logic        sr_req_i = 1'b0;
  logic        gnt_i = 1'b0;
  logic        req_o, urgent_o, cke_o, page_inv_o;
  logic [1:0]  cmd_o;
  logic [3:0]  pending_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  refresh_sched i_refresh_sched (
    .clk(clk), .rst_n(rst_n), .rate_i(rate_i), .trfc_i(trfc_i), .xsr_i(xsr_i),
    .thresh_i(thresh_i), .sr_req_i(sr_req_i), .gnt_i(gnt_i), .req_o(req_o),
    .urgent_o(urgent_o), .cmd_o(cmd_o), .cke_o(cke_o), .page_inv_o(page_inv_o),
    .pending_o(pending_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // R2 R3 R4: grant withheld, backlog follows the closed form
  task automatic sweep_wait(input int rate);
    int prev = 0;
    rate_i = 16'(rate); thresh_i = 4'd3; gnt_i = 1'b0; sr_req_i = 1'b0;
    do_reset();
    for (int n = 1; n <= 50; n++) begin
      int raw, exp;
      @(negedge clk);
      raw = n / (rate + 1);
      exp = (raw > 15) ? 15 : raw;
      if (raw > 15) chk(pending_o == 4'(exp), "R3 saturate", pending_o, exp);
      else          chk(pending_o == 4'(exp), "R2 interval", pending_o, exp);
      chk(req_o == (prev > 0), "R4 request", req_o, prev > 0);
      chk(urgent_o == (req_o && exp >= 3), "R4 urgency", urgent_o, req_o && exp >= 3);
      prev = exp;
    end
  endtask

  // R5 R6 R7: granted refresh sequences
  task automatic sweep_refresh(input int rate, input int trfc, input int cycles);
    int arefs = 0;
    int gaprun = -1;
    logic [1:0] prevcmd = 2'd0;
    rate_i = 16'(rate); trfc_i = 8'(trfc); thresh_i = 4'd15; gnt_i = 1'b1; sr_req_i = 1'b0;
    do_reset();
    for (int n = 1; n <= cycles; n++) begin
      int exp;
      @(negedge clk);
      exp = n / (rate + 1) - arefs;
      chk(pending_o == 4'(exp), "R7 backlog", pending_o, exp);
      chk(page_inv_o == (cmd_o == 2'd1), "R5 invalidate", page_inv_o, cmd_o == 2'd1);
      chk(cke_o == 1'b1, "R6 cke", cke_o, 1);
      if (!req_o) chk(cmd_o == 2'd0, "R6 idle nop", cmd_o, 0);
      if (cmd_o == 2'd2) begin
        chk(prevcmd == 2'd1, "R5 prea first", prevcmd, 1);
        arefs++;
        gaprun = 0;
      end else if (gaprun >= 0) begin
        if (req_o) begin
          chk(cmd_o == 2'd0, "R6 gap nop", cmd_o, 0);
          gaprun++;
        end else begin
          chk(gaprun == trfc, "R6 gap length", gaprun, trfc);
          gaprun = -1;
        end
      end
      prevcmd = cmd_o;
    end
    chk(arefs > 0, "R5 refreshes issued", arefs, 1);
  endtask

  // R8 R9: self-refresh entry, residency and exit
  task automatic self_refresh(input int xsr);
    rate_i = 16'd9; xsr_i = 8'(xsr); gnt_i = 1'b1; sr_req_i = 1'b1;
    do_reset();
    @(negedge clk);
    chk(req_o && cmd_o == 2'd0, "R8 request", req_o, 1);
    @(negedge clk);
    chk(cmd_o == 2'd1 && page_inv_o, "R8 prea", cmd_o, 1);
    @(negedge clk);
    chk(cmd_o == 2'd3 && !cke_o, "R8 entry", cmd_o, 3);
    for (int n = 4; n <= 22; n++) begin
      @(negedge clk);
      chk(!cke_o && req_o && cmd_o == 2'd0, "R8 resident", cke_o, 0);
    end
    chk(pending_o == 4'd2, "R7 owed in self-refresh", pending_o, 2);
    sr_req_i = 1'b0;
    for (int k = 0; k < xsr; k++) begin
      @(negedge clk);
      chk(cke_o && req_o && cmd_o == 2'd0, "R9 exit wait", {cke_o, req_o}, 3);
    end
    @(negedge clk);
    chk(!req_o, "R9 release", req_o, 0);
    chk(pending_o == 4'd0, "R9 cleared", pending_o, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=1 expected=0");
    finish_run();
  end

  initial begin
    do_reset();
    // R1
    chk(!req_o && !urgent_o && !page_inv_o, "R1 reset flags", {req_o, urgent_o, page_inv_o}, 0);
    chk(cmd_o == 2'd0 && cke_o, "R1 reset cmd", cmd_o, 0);
    chk(pending_o == 4'd0, "R1 reset backlog", pending_o, 0);
    sweep_wait(1);
    sweep_wait(2);
    sweep_wait(4);
    sweep_refresh(9, 3, 150);
    sweep_refresh(6, 1, 150);
    sweep_refresh(8, 5, 150);
    sweep_refresh(4, 6, 100);
    self_refresh(1);
    self_refresh(4);
    finish_run();
  end
endmodule